// File: doc/BRIEF.md
# Compact 16-bit instruction executor

This block decodes and carries out the short, two-byte instruction group of a 32-bit processor that has sixteen general registers. Each accepted instruction word arrives with a valid strobe and its program counter. The block drives two combinational read-index outputs into the register file and takes the two operand values back in the same cycle. One cycle later it presents its registered results. These are a register write-back (index, data, enable), a memory request (address, write data, write flag, valid), and a next-PC report that either steps the counter by two or redirects it for a return.

Loads are split in two. The request leaves one cycle after the instruction is accepted. The block then drops `in_ready` and waits for the memory response, which it writes back one cycle after it arrives. Only one load can be outstanding at a time.

Any word that is not a legal short instruction raises a one-cycle illegal flag and produces neither a write-back, a memory access nor a redirect. This includes words whose opcode nibble marks a three-byte instruction.

Top module: `cnx_exec`

## Requirements
- R1: After reset, every registered output is low and `in_ready` is high.
- R2: The instruction fields are op = bits [3:0], t = bits [7:4], s = bits [11:8] and r = bits [15:12]. An op value below 8 (a long instruction), or an op of 14 or 15, raises `illegal` for one cycle with no write-back, memory request or redirect.
- R3: For op 8 (load word), a read request goes out one cycle after acceptance, to address reg[s] + 4*r. One cycle after `mem_rvalid`, `wb_en` is asserted with index t and data `mem_rdata`.
- R4: For op 9 (store word), a write request goes out one cycle after acceptance, to address reg[s] + 4*r, with write data reg[t]. There is no write-back.
- R5: For op 10, reg[s] + reg[t] is written to register r one cycle after acceptance.
- R6: For op 11, reg[s] + k is written to register r, where k = t when t is nonzero and k = -1 when t is zero.
- R7: For op 12 with t < 8, register s receives the value t*16 + r. When t is 6 or 7, bits 31..7 are set to ones, giving a range of -32..95. Op 12 with t >= 8 is illegal.
- R8: For op 13 with r = 0, reg[s] is written to register t.
- R9: For op 13 with r = 15 and t = 0 (return), `rd_a_idx` is 0 while the word is offered. One cycle later `npc_redirect` is high and `npc` equals the value of register 0.
- R10: Op 13 with r = 15 and t = 3 is a no-operation. It produces no write-back, memory request, redirect or illegal flag.
- R11: Op 13 with r other than 0 or 15, and op 13 with r = 15 and t other than 0 or 3, raise `illegal` with no other effect.
- R12: While a load is outstanding, `in_ready` is low. An instruction offered then is ignored and produces no output.
- R13: Every accepted instruction pulses `npc_valid` one cycle later. When there is no redirect, `npc` is the accepted PC + 2.
- R14: While a word is offered, `rd_a_idx` equals s (except for a return) and `rd_b_idx` equals t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Block can accept a word |
| in_instr | input | 16 | Instruction word |
| in_pc | input | 32 | Address of the offered word |
| rd_a_idx | output | 4 | First register read index |
| rd_a_data | input | 32 | First operand value |
| rd_b_idx | output | 4 | Second register read index |
| rd_b_data | input | 32 | Second operand value |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | 4 | Write-back register index |
| wb_data | output | 32 | Write-back value |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Store data |
| mem_rvalid | input | 1 | Load response valid |
| mem_rdata | input | 32 | Load response data |
| npc_valid | output | 1 | Next-PC report strobe |
| npc_redirect | output | 1 | Next PC comes from a return |
| npc | output | 32 | Next program counter |
| illegal | output | 1 | Rejected encoding |

## Verification
The hardest state to reach from the ports is the one where a load is outstanding and a new word is offered. It only exists when the memory side holds its response back. The bench therefore answers each load after a random delay of zero to three cycles. During that wait it offers a further instruction and checks that the offered word leaves no trace and that `in_ready` stays low. The irregular immediate corners are also driven directly: the zero add constant and the move values at -32, -1 and 95. Seeded random words cover all sixteen op values.

// File: rtl/cnx_pkg.sv
package cnx_pkg;

    localparam int unsigned IW    = 16;
    localparam int unsigned RIDXW = 4;

    typedef struct packed {
        logic [3:0] r;
        logic [3:0] s;
        logic [3:0] t;
        logic [3:0] op;
    } nfields_t;

    typedef enum logic [3:0] {
        K_LOAD,
        K_STORE,
        K_ADD,
        K_ADDI,
        K_MOVI,
        K_MOV,
        K_RET,
        K_NOP,
        K_ILL
    } kind_e;

endpackage

// File: rtl/cnx_decode.sv
module cnx_decode
    import cnx_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [IW-1:0]    instr,
    output kind_e            kind,
    output nfields_t         fld,
    output logic [XLEN-1:0]  imm_add,
    output logic [XLEN-1:0]  imm_mov,
    output logic [XLEN-1:0]  mem_off,
    output logic [RIDXW-1:0] idx_a,
    output logic [RIDXW-1:0] idx_b
);

    logic neg_mov;

    assign fld = nfields_t'(instr);

    always_comb begin
        kind = K_ILL;
        unique case (fld.op)
            4'd8:  kind = K_LOAD;
            4'd9:  kind = K_STORE;
            4'd10: kind = K_ADD;
            4'd11: kind = K_ADDI;
            4'd12: begin
                if (!fld.t[3]) kind = K_MOVI;
            end
            4'd13: begin
                if (fld.r == 4'd0) begin
                    kind = K_MOV;
                end else if (fld.r == 4'hF) begin
                    if (fld.t == 4'd0)      kind = K_RET;
                    else if (fld.t == 4'd3) kind = K_NOP;
                end
            end
            default: kind = K_ILL;
        endcase
    end

    // add constant: zero field encodes minus one
    assign imm_add = (fld.t == 4'd0) ? {XLEN{1'b1}} : XLEN'(fld.t);

    // move constant: ones above bit 6 when t[2:1] are both set
    assign neg_mov = (fld.t[2:1] == 2'b11);
    assign imm_mov = {{(XLEN-7){neg_mov}}, fld.t[2:0], fld.r};

    assign mem_off = XLEN'({fld.r, 2'b00});

    assign idx_a = (kind == K_RET) ? '0 : fld.s;
    assign idx_b = fld.t;

endmodule

// File: rtl/cnx_execute.sv
module cnx_execute
    import cnx_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  kind_e            kind,
    input  nfields_t         fld,
    input  logic [XLEN-1:0]  imm_add,
    input  logic [XLEN-1:0]  imm_mov,
    input  logic [XLEN-1:0]  mem_off,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    output logic             x_wb_en,
    output logic [RIDXW-1:0] x_wb_idx,
    output logic [XLEN-1:0]  x_wb_data,
    output logic             x_mem_req,
    output logic             x_mem_we,
    output logic [XLEN-1:0]  x_mem_addr,
    output logic [XLEN-1:0]  x_mem_wdata,
    output logic             x_is_load,
    output logic             x_redirect,
    output logic [XLEN-1:0]  x_target,
    output logic             x_illegal
);

    logic [XLEN-1:0] eff_addr;

    assign eff_addr = opa + mem_off;

    always_comb begin
        x_wb_en     = 1'b0;
        x_wb_idx    = '0;
        x_wb_data   = '0;
        x_mem_req   = 1'b0;
        x_mem_we    = 1'b0;
        x_mem_addr  = '0;
        x_mem_wdata = '0;
        x_is_load   = 1'b0;
        x_redirect  = 1'b0;
        x_target    = '0;
        x_illegal   = 1'b0;
        unique case (kind)
            K_LOAD: begin
                x_mem_req  = 1'b1;
                x_mem_addr = eff_addr;
                x_is_load  = 1'b1;
            end
            K_STORE: begin
                x_mem_req   = 1'b1;
                x_mem_we    = 1'b1;
                x_mem_addr  = eff_addr;
                x_mem_wdata = opb;
            end
            K_ADD: begin
                x_wb_en   = 1'b1;
                x_wb_idx  = fld.r;
                x_wb_data = opa + opb;
            end
            K_ADDI: begin
                x_wb_en   = 1'b1;
                x_wb_idx  = fld.r;
                x_wb_data = opa + imm_add;
            end
            K_MOVI: begin
                x_wb_en   = 1'b1;
                x_wb_idx  = fld.s;
                x_wb_data = imm_mov;
            end
            K_MOV: begin
                x_wb_en   = 1'b1;
                x_wb_idx  = fld.t;
                x_wb_data = opa;
            end
            K_RET: begin
                x_redirect = 1'b1;
                x_target   = opa;
            end
            K_NOP: begin
            end
            default: x_illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/cnx_exec.sv
module cnx_exec
    import cnx_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned PC_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [15:0]      in_instr,
    input  logic [XLEN-1:0]  in_pc,
    output logic [3:0]       rd_a_idx,
    input  logic [XLEN-1:0]  rd_a_data,
    output logic [3:0]       rd_b_idx,
    input  logic [XLEN-1:0]  rd_b_data,
    output logic             wb_en,
    output logic [3:0]       wb_idx,
    output logic [XLEN-1:0]  wb_data,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic             mem_rvalid,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             npc_valid,
    output logic             npc_redirect,
    output logic [XLEN-1:0]  npc,
    output logic             illegal
);

    localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

    typedef struct packed {
        logic             busy;
        logic [RIDXW-1:0] ld_idx;
        logic             wb_en;
        logic [RIDXW-1:0] wb_idx;
        logic [XLEN-1:0]  wb_data;
        logic             mem_req;
        logic             mem_we;
        logic [XLEN-1:0]  mem_addr;
        logic [XLEN-1:0]  mem_wdata;
        logic             npc_valid;
        logic             npc_redirect;
        logic [XLEN-1:0]  npc;
        logic             illegal;
    } state_t;

    state_t st_d, st_q;

    kind_e            dk;
    nfields_t         dfld;
    logic [XLEN-1:0]  imm_add, imm_mov, mem_off;
    logic             x_wb_en, x_mem_req, x_mem_we, x_is_load, x_redirect, x_illegal;
    logic [RIDXW-1:0] x_wb_idx;
    logic [XLEN-1:0]  x_wb_data, x_mem_addr, x_mem_wdata, x_target;
    logic             accept;

    cnx_decode #(.XLEN(XLEN)) u_dec (
        .instr   (in_instr),
        .kind    (dk),
        .fld     (dfld),
        .imm_add (imm_add),
        .imm_mov (imm_mov),
        .mem_off (mem_off),
        .idx_a   (rd_a_idx),
        .idx_b   (rd_b_idx)
    );

    cnx_execute #(.XLEN(XLEN)) u_exe (
        .kind        (dk),
        .fld         (dfld),
        .imm_add     (imm_add),
        .imm_mov     (imm_mov),
        .mem_off     (mem_off),
        .opa         (rd_a_data),
        .opb         (rd_b_data),
        .x_wb_en     (x_wb_en),
        .x_wb_idx    (x_wb_idx),
        .x_wb_data   (x_wb_data),
        .x_mem_req   (x_mem_req),
        .x_mem_we    (x_mem_we),
        .x_mem_addr  (x_mem_addr),
        .x_mem_wdata (x_mem_wdata),
        .x_is_load   (x_is_load),
        .x_redirect  (x_redirect),
        .x_target    (x_target),
        .x_illegal   (x_illegal)
    );

    assign in_ready = !st_q.busy;
    assign accept   = in_valid && in_ready;

    always_comb begin
        st_d              = st_q;
        st_d.wb_en        = 1'b0;
        st_d.mem_req      = 1'b0;
        st_d.mem_we       = 1'b0;
        st_d.npc_valid    = 1'b0;
        st_d.npc_redirect = 1'b0;
        st_d.illegal      = 1'b0;
        if (st_q.busy && mem_rvalid) begin
            st_d.busy    = 1'b0;
            st_d.wb_en   = 1'b1;
            st_d.wb_idx  = st_q.ld_idx;
            st_d.wb_data = mem_rdata;
        end else if (accept) begin
            st_d.wb_en        = x_wb_en;
            st_d.wb_idx       = x_wb_idx;
            st_d.wb_data      = x_wb_data;
            st_d.mem_req      = x_mem_req;
            st_d.mem_we       = x_mem_we;
            st_d.mem_addr     = x_mem_addr;
            st_d.mem_wdata    = x_mem_wdata;
            st_d.npc_valid    = 1'b1;
            st_d.npc_redirect = x_redirect;
            st_d.npc          = x_redirect ? x_target : in_pc + STEP;
            st_d.illegal      = x_illegal;
            if (x_is_load) begin
                st_d.busy   = 1'b1;
                st_d.ld_idx = dfld.t;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wb_en        = st_q.wb_en;
    assign wb_idx       = st_q.wb_idx;
    assign wb_data      = st_q.wb_data;
    assign mem_req      = st_q.mem_req;
    assign mem_we       = st_q.mem_we;
    assign mem_addr     = st_q.mem_addr;
    assign mem_wdata    = st_q.mem_wdata;
    assign npc_valid    = st_q.npc_valid;
    assign npc_redirect = st_q.npc_redirect;
    assign npc          = st_q.npc;
    assign illegal      = st_q.illegal;

    a_r2_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wb_en && !mem_req && !npc_redirect));

    a_r12_load_tracked: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !in_ready);

    a_r12_blocked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !mem_rvalid) |=> (!npc_valid && !wb_en && !mem_req));

    a_r3_load_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && mem_rvalid) |=> (wb_en && in_ready));

    a_r13_step_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (npc_valid && !npc_redirect) |-> (npc == $past(in_pc) + STEP));

    a_r1_single_effect: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_en, mem_req, illegal, npc_redirect}));

endmodule

// File: tb/cnx_exec_test.sv
module cnx_exec_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_instr = '0;
    logic [31:0] in_pc = '0;
    logic [3:0]  rd_a_idx, rd_b_idx;
    logic [31:0] rd_a_data, rd_b_data;
    logic        wb_en;
    logic [3:0]  wb_idx;
    logic [31:0] wb_data;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        npc_valid, npc_redirect, illegal;
    logic [31:0] npc;

    logic [31:0] regs [16];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign rd_a_data = regs[rd_a_idx];
    assign rd_b_data = regs[rd_b_idx];

    cnx_exec uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .in_pc(in_pc),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .npc_valid(npc_valid), .npc_redirect(npc_redirect), .npc(npc), .illegal(illegal)
    );

    // expected results
    logic        e_ill, e_wb, e_mem, e_we, e_red, e_load;
    logic [3:0]  e_wbidx, e_ra;
    logic [31:0] e_wbdata, e_addr, e_wdata, e_npc;
    string       e_req;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] movi_val(input logic [3:0] t, input logic [3:0] r);
        int v;
        v = t * 16 + r;
        if (t == 4'd6 || t == 4'd7) v = v - 128;
        return 32'(v);
    endfunction

    task automatic model(input logic [15:0] w, input logic [31:0] pc);
        logic [3:0] op, t, s, r;
        op = w[3:0]; t = w[7:4]; s = w[11:8]; r = w[15:12];
        e_ill = 0; e_wb = 0; e_mem = 0; e_we = 0; e_red = 0; e_load = 0;
        e_wbidx = 0; e_wbdata = 0; e_addr = 0; e_wdata = 0;
        e_ra = s; e_npc = pc + 32'd2; e_req = "R2";
        if (op == 4'd8) begin
            e_req = "R3"; e_mem = 1; e_load = 1; e_addr = regs[s] + 32'(r) * 4;
        end else if (op == 4'd9) begin
            e_req = "R4"; e_mem = 1; e_we = 1; e_addr = regs[s] + 32'(r) * 4; e_wdata = regs[t];
        end else if (op == 4'd10) begin
            e_req = "R5"; e_wb = 1; e_wbidx = r; e_wbdata = regs[s] + regs[t];
        end else if (op == 4'd11) begin
            e_req = "R6"; e_wb = 1; e_wbidx = r;
            e_wbdata = regs[s] + ((t == 0) ? 32'hFFFF_FFFF : 32'(t));
        end else if (op == 4'd12) begin
            e_req = "R7";
            if (t < 8) begin e_wb = 1; e_wbidx = s; e_wbdata = movi_val(t, r); end
            else e_ill = 1;
        end else if (op == 4'd13) begin
            if (r == 0) begin
                e_req = "R8"; e_wb = 1; e_wbidx = t; e_wbdata = regs[s];
            end else if (r == 15 && t == 0) begin
                e_req = "R9"; e_red = 1; e_ra = 0; e_npc = regs[0];
            end else if (r == 15 && t == 3) begin
                e_req = "R10";
            end else begin
                e_req = "R11"; e_ill = 1;
            end
        end else begin
            e_ill = 1;
        end
    endtask

    task automatic fill_regs();
        for (int i = 0; i < 16; i++) regs[i] = $urandom;
    endtask

    // offer one word, check everything, complete a load after dly cycles
    task automatic run_one(input logic [15:0] w, input logic [31:0] pc, input int dly);
        logic [31:0] rd;
        fill_regs();
        model(w, pc);
        in_instr = w; in_pc = pc; in_valid = 1'b1;
        #1;
        chk({"R14 idx_a ", e_req}, 32'(rd_a_idx), 32'(e_ra));
        chk("R14 idx_b", 32'(rd_b_idx), 32'(w[7:4]));
        @(negedge clk);
        in_valid = 1'b0;
        chk({"R13 npc_valid ", e_req}, 32'(npc_valid), 32'd1);
        chk({e_req, " illegal"}, 32'(illegal), 32'(e_ill));
        chk({e_req, " redirect"}, 32'(npc_redirect), 32'(e_red));
        chk({e_req, " npc R13"}, npc, e_npc);
        chk({e_req, " wb_en"}, 32'(wb_en), 32'(e_wb));
        if (e_wb) begin
            chk({e_req, " wb_idx"}, 32'(wb_idx), 32'(e_wbidx));
            chk({e_req, " wb_data"}, wb_data, e_wbdata);
        end
        chk({e_req, " mem_req"}, 32'(mem_req), 32'(e_mem));
        if (e_mem) begin
            chk({e_req, " mem_we"}, 32'(mem_we), 32'(e_we));
            chk({e_req, " mem_addr"}, mem_addr, e_addr);
            if (e_we) chk({e_req, " mem_wdata"}, mem_wdata, e_wdata);
        end
        if (e_load) begin
            for (int k = 0; k < dly; k++) begin
                chk("R12 in_ready low", 32'(in_ready), 32'd0);
                in_instr = {4'd1, 4'd2, 4'd3, 4'd10}; in_valid = 1'b1;
                @(negedge clk);
                in_valid = 1'b0;
                chk("R12 blocked npc_valid", 32'(npc_valid), 32'd0);
                chk("R12 blocked wb_en", 32'(wb_en), 32'd0);
                chk("R12 blocked mem_req", 32'(mem_req), 32'd0);
            end
            rd = $urandom;
            mem_rdata = rd; mem_rvalid = 1'b1;
            @(negedge clk);
            mem_rvalid = 1'b0;
            chk("R3 load wb_en", 32'(wb_en), 32'd1);
            chk("R3 load wb_idx", 32'(wb_idx), 32'(w[7:4]));
            chk("R3 load wb_data", wb_data, rd);
            chk("R12 ready after load", 32'(in_ready), 32'd1);
        end
    endtask

    initial begin : watchdog
        int n;
        n = 0;
        while (!done && n < 150000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] w;
        void'($urandom(32'd1234));
        fill_regs();
        repeat (3) @(negedge clk);
        chk("R1 in_ready", 32'(in_ready), 32'd1);
        chk("R1 outputs", 32'({wb_en, mem_req, npc_valid, npc_redirect, illegal}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", 32'({wb_en, mem_req, npc_valid, illegal}), 32'd0);

        run_one({4'd3, 4'd5, 4'd7, 4'd8}, 32'h100, 0);   // R3 load immediate answer
        run_one({4'd15, 4'd2, 4'd9, 4'd8}, 32'h104, 3);  // R3 R12 delayed answer
        run_one({4'd2, 4'd4, 4'd6, 4'd9}, 32'h108, 0);   // R4 store
        run_one({4'd1, 4'd2, 4'd3, 4'd10}, 32'h10A, 0);  // R5 add
        run_one({4'd4, 4'd6, 4'd0, 4'd11}, 32'h10C, 0);  // R6 zero means -1
        run_one({4'd4, 4'd6, 4'd15, 4'd11}, 32'h10E, 0); // R6
        run_one({4'd0, 4'd3, 4'd6, 4'd12}, 32'h110, 0);  // R7 -32
        run_one({4'd15, 4'd3, 4'd7, 4'd12}, 32'h112, 0); // R7 -1
        run_one({4'd15, 4'd3, 4'd5, 4'd12}, 32'h114, 0); // R7 95
        run_one({4'd1, 4'd3, 4'd8, 4'd12}, 32'h116, 0);  // R7 illegal t>=8
        run_one({4'd0, 4'd9, 4'd4, 4'd13}, 32'h118, 0);  // R8 mov
        run_one({4'd15, 4'd7, 4'd0, 4'd13}, 32'h11A, 0); // R9 return
        run_one({4'd15, 4'd7, 4'd3, 4'd13}, 32'h11C, 0); // R10 nop
        run_one({4'd1, 4'd7, 4'd3, 4'd13}, 32'h11E, 0);  // R11
        run_one({4'd15, 4'd7, 4'd1, 4'd13}, 32'h120, 0); // R11
        run_one({4'd2, 4'd7, 4'd3, 4'd3}, 32'h122, 0);   // R2 long word
        run_one({4'd2, 4'd7, 4'd3, 4'd14}, 32'hFFFF_FFFE, 0); // R2 R13 wrap

        for (int i = 0; i < 400; i++) begin
            w = $urandom;
            if (i % 3 == 0) w[3] = 1'b1;
            run_one(w, $urandom & 32'hFFFF_FFFE, $urandom_range(0, 3));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule